// File: doc/BRIEF.md
# Crate Status Link Transceiver

This block swaps a seven-flag health word with a neighbouring crate over a slow asynchronous serial line. On the transmit side it takes a snapshot of the local flags and sends it as a short character frame. That frame is one low start bit, seven data bits sent least significant first, no parity bit and one high stop bit. As soon as one frame ends, the next begins, so the neighbour always holds a recent copy. On the receive side it passes the incoming line through a two-flop synchroniser and checks the start bit at its midpoint. It samples every following bit at its centre, using a 16x oversampling tick, and keeps the last frame whose stop bit was high.

Bits 0 to 6 of the payload carry, in order: watchdog healthy, temperature-not-OK (active low), CPU status (active low), CPU run (active low), plus-minus 12 V healthy, +5 V healthy and CPU fail (active low). A 16-bit read port presents the held received flags in bits 6:0 and the snapshot now being sent in bits 14:8. Bits 7 and 15 read as zero. The read register loads only in cycles where the read strobe is high.

The transmitter runs the states TX_IDLE (after reset until the first tick), TX_START, TX_DATA and TX_STOP. TX_STOP leads straight back to TX_START, and each entry to TX_START takes a new snapshot. The receiver runs the states RX_IDLE and RX_START (mid-start confirmation). A false start returns to RX_IDLE. RX_DATA leads to RX_STOP. A high stop bit commits the frame and returns to RX_IDLE. A low stop bit goes to RX_BREAK, which waits for the line to return high and then goes to RX_IDLE.

Top module: `statlink_xcvr`

## Requirements
- R1: In reset, and in the first cycle after it, tx_line is high and rd_data is zero. The received field (rd_data[6:0]) stays zero until the first valid frame.
- R2: Each transmitted frame is one low start bit, then status bits 0..6 least significant first, then one high stop bit. Each bit lasts 16 ticks, and a tick comes every TICK_DIV clocks.
- R3: Frames are sent back to back: the next start bit follows the stop bit at once. Each frame carries the status_in value taken when its start bit begins.
- R4: rd_data[14:8] shows the snapshot of the frame now on the line. rd_data[7] and rd_data[15] always read zero.
- R5: A frame on rx_line with a high stop bit is decoded with centre sampling. Its seven bits appear in rd_data[6:0] with the first data bit in bit 0.
- R6: A frame whose stop bit is low is dropped and the previously held flags stay. The receiver waits for the line to go high before it looks for a new start, so a later valid frame is accepted.
- R7: A low pulse on rx_line shorter than half a bit is not taken as a start bit and changes nothing.
- R8: rd_data loads the status word only in cycles after rd_en is high. Otherwise it holds its value, even when a new frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_in | input | 7 | Local status flags to transmit |
| rx_line | input | 1 | Serial line from the neighbour, idles high |
| rd_en | input | 1 | Read strobe for the status register |
| tx_line | output | 1 | Serial line to the neighbour, idles high |
| rd_data | output | 16 | Status register: received flags low, sent flags high |

## Verification
A wrong transmit state or bit counter shows on tx_line within one bit time. It appears as a misplaced start edge, a wrong data bit or a stretched gap between frames, and an independent decoder sampling at bit centres catches each of these. A wrong receive state shows in rd_data[6:0] one or two cycles after the stop-bit centre, or, for a lost or spurious commit, as a held value that drifts from the model between frames. The reference model checks that byte on every clock. A snapshot taken at the wrong moment shows as a mismatch between rd_data[14:8] and the decoded frame.

// File: rtl/statlink_pkg.sv
package statlink_pkg;
    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BREAK
    } rx_state_e;
endpackage

// File: rtl/statlink_tick.sv
module statlink_tick #(
    parameter int TICK_DIV = 1628
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV_W = $clog2(TICK_DIV + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == DIV_LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    assign tick = (cnt_q == DIV_LAST);

    generate
        if (TICK_DIV > 1) begin : g_gap_chk
            assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/statlink_tx.sv
module statlink_tx
    import statlink_pkg::*;
#(
    parameter int DATA_BITS = 7,
    parameter int OSR       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [DATA_BITS-1:0] status_in,
    output logic                 tx_line,
    output logic [DATA_BITS-1:0] snap_out
);
    localparam int SUB_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_BITS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

    tx_state_e            state_q, state_d;
    logic [SUB_W-1:0]     sub_q;
    logic [IDX_W-1:0]     idx_q;
    logic [DATA_BITS-1:0] snap_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                TX_IDLE:  state_d = TX_START;
                TX_START: if (sub_q == SUB_LAST) state_d = TX_DATA;
                TX_DATA:  if (sub_q == SUB_LAST && idx_q == IDX_LAST) state_d = TX_STOP;
                TX_STOP:  if (sub_q == SUB_LAST) state_d = TX_START;
                default:  state_d = TX_IDLE;
            endcase
        end
    end

    // counters and snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q  <= '0;
            idx_q  <= '0;
            snap_q <= '0;
        end else if (tick) begin
            unique case (state_q)
                TX_IDLE: begin
                    snap_q <= status_in;
                    sub_q  <= '0;
                end
                TX_START: begin
                    idx_q <= '0;
                    sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + SUB_W'(1);
                end
                TX_DATA: begin
                    sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + SUB_W'(1);
                    if (sub_q == SUB_LAST && idx_q != IDX_LAST)
                        idx_q <= idx_q + IDX_W'(1);
                end
                TX_STOP: begin
                    sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + SUB_W'(1);
                    if (sub_q == SUB_LAST)
                        snap_q <= status_in;
                end
                default: sub_q <= '0;
            endcase
        end
    end

    // line output
    always_comb begin
        unique case (state_q)
            TX_IDLE:  tx_line = 1'b1;
            TX_START: tx_line = 1'b0;
            TX_DATA:  tx_line = snap_q[idx_q];
            TX_STOP:  tx_line = 1'b1;
            default:  tx_line = 1'b1;
        endcase
    end

    assign snap_out = snap_q;

    assert_snap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(snap_q) |-> ($past(state_q) == TX_STOP || $past(state_q) == TX_IDLE));
    assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_LAST);
    assert_stop_to_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == TX_STOP && state_q != TX_STOP) |-> state_q == TX_START);
endmodule

// File: rtl/statlink_rx.sv
module statlink_rx
    import statlink_pkg::*;
#(
    parameter int DATA_BITS = 7,
    parameter int OSR       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rx_line,
    output logic [DATA_BITS-1:0] hold_out
);
    localparam int SUB_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_BITS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
    localparam logic [SUB_W-1:0] SUB_HALF = SUB_W'(OSR / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

    rx_state_e            state_q, state_d;
    logic                 meta_q, line_s;
    logic [SUB_W-1:0]     sub_q;
    logic [IDX_W-1:0]     idx_q;
    logic [DATA_BITS-1:0] shift_q;
    logic [DATA_BITS-1:0] hold_q;

    // two-flop synchroniser, idles high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            line_s <= 1'b1;
        end else begin
            meta_q <= rx_line;
            line_s <= meta_q;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                RX_IDLE:  if (!line_s) state_d = RX_START;
                RX_START: if (sub_q == SUB_HALF) state_d = line_s ? RX_IDLE : RX_DATA;
                RX_DATA:  if (sub_q == SUB_LAST && idx_q == IDX_LAST) state_d = RX_STOP;
                RX_STOP:  if (sub_q == SUB_LAST) state_d = line_s ? RX_IDLE : RX_BREAK;
                RX_BREAK: if (line_s) state_d = RX_IDLE;
                default:  state_d = RX_IDLE;
            endcase
        end
    end

    // sampling datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q   <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            hold_q  <= '0;
        end else if (tick) begin
            unique case (state_q)
                RX_IDLE: sub_q <= '0;
                RX_START: begin
                    idx_q <= '0;
                    sub_q <= (sub_q == SUB_HALF) ? '0 : sub_q + SUB_W'(1);
                end
                RX_DATA: begin
                    if (sub_q == SUB_LAST) begin
                        sub_q          <= '0;
                        shift_q[idx_q] <= line_s;
                        if (idx_q != IDX_LAST) idx_q <= idx_q + IDX_W'(1);
                    end else begin
                        sub_q <= sub_q + SUB_W'(1);
                    end
                end
                RX_STOP: begin
                    if (sub_q == SUB_LAST) begin
                        sub_q <= '0;
                        if (line_s) hold_q <= shift_q;
                    end else begin
                        sub_q <= sub_q + SUB_W'(1);
                    end
                end
                RX_BREAK: sub_q <= '0;
                default:  sub_q <= '0;
            endcase
        end
    end

    assign hold_out = hold_q;

    assert_commit_only_good_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hold_q) |-> ($past(state_q) == RX_STOP && $past(line_s)));
    assert_start_confirmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_DATA && $past(state_q) == RX_START) |-> !$past(line_s));
    assert_break_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == RX_BREAK && state_q != RX_BREAK) |-> $past(line_s));
endmodule

// File: rtl/statlink_xcvr.sv
module statlink_xcvr #(
    parameter int CLK_HZ    = 250_000_000,
    parameter int BAUD      = 9600,
    parameter int OSR       = 16,
    parameter int DATA_BITS = 7,
    parameter int TICK_DIV  = CLK_HZ / (BAUD * OSR)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DATA_BITS-1:0]       status_in,
    input  logic                       rx_line,
    input  logic                       rd_en,
    output logic                       tx_line,
    output logic [2*(DATA_BITS+1)-1:0] rd_data
);
    localparam int WORD_W = 2 * (DATA_BITS + 1);

    logic                 tick;
    logic [DATA_BITS-1:0] tx_snap;
    logic [DATA_BITS-1:0] rx_hold;
    logic [WORD_W-1:0]    rd_q;

    statlink_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    statlink_tx #(.DATA_BITS(DATA_BITS), .OSR(OSR)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .status_in (status_in),
        .tx_line   (tx_line),
        .snap_out  (tx_snap)
    );

    statlink_rx #(.DATA_BITS(DATA_BITS), .OSR(OSR)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rx_line  (rx_line),
        .hold_out (rx_hold)
    );

    // read register: received flags low, sent flags high, pad bits zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= {1'b0, tx_snap, 1'b0, rx_hold};
    end

    assign rd_data = rd_q;

    assert_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[DATA_BITS] == 1'b0 && rd_data[WORD_W-1] == 1'b0));
    assert_read_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rd_data));
endmodule

// File: tb/statlink_xcvr_tb.sv
module statlink_xcvr_tb;
    localparam int DIV  = 2;
    localparam int BITC = 16 * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  status_in = 7'h2A;
    logic        rx_line = 1'b1;
    logic        rd_en = 1'b1;
    logic        tx_line;
    logic [15:0] rd_data;

    always #2 clk = ~clk;

    statlink_xcvr #(.TICK_DIV(DIV)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_in (status_in),
        .rx_line   (rx_line),
        .rd_en     (rd_en),
        .tx_line   (tx_line),
        .rd_data   (rd_data)
    );

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;
    bit   cmp_en = 1;
    bit   rx_busy = 0;
    logic [6:0] exp_rx = 7'h00;
    logic [6:0] cur_st = 7'h2A;
    logic [6:0] prev_st = 7'h2A;
    int   fsince = 2;
    int   frames = 0;

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock model comparison of the receive field and pad bits
    always @(negedge clk) begin
        if (rst_n) begin
            check(rd_data[7] == 1'b0 && rd_data[15] == 1'b0, "R4 pad bits zero",
                  {rd_data[15], 7'h0, rd_data[7], 7'h0}, 16'h0);
            if (cmp_en && !rx_busy)
                check(rd_data[7:0] == {1'b0, exp_rx}, "R1 R5 received field vs model",
                      {8'h0, rd_data[7:0]}, {9'h0, exp_rx});
        end
    end

    // independent centre-sampling decoder of tx_line
    logic       tx_prev = 1'b1;
    int         dphase = 0;
    int         dcnt = 0;
    int         gap = -1;
    logic [6:0] dbits = '0;
    logic [6:0] hb = '0;
    bit         hb_ok = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            tx_prev = 1'b1; dphase = 0; gap = -1;
        end else begin
            if (dphase == 0) begin
                if (gap >= 0) gap++;
                if (tx_prev && !tx_line) begin
                    if (gap >= 0)
                        check(gap >= BITC/2 - 3 && gap <= BITC/2 + 3, "R3 back-to-back start",
                              16'(gap), 16'(BITC/2));
                    dphase = 1; dcnt = 0;
                end
            end else begin
                dcnt++;
                if (dcnt == BITC/2) begin
                    check(tx_line == 1'b0, "R2 start bit low", {15'h0, tx_line}, 16'h0);
                    hb = rd_data[14:8];
                    hb_ok = rd_en && cmp_en;
                end else if (dcnt > BITC/2 && (dcnt - BITC/2) % BITC == 0) begin
                    automatic int k = (dcnt - BITC/2) / BITC;
                    if (k <= 7) begin
                        dbits[k-1] = tx_line;
                    end else begin
                        check(tx_line == 1'b1, "R2 stop bit high", {15'h0, tx_line}, 16'h1);
                        if (fsince >= 2)
                            check(dbits == cur_st, "R2 R3 frame payload", {9'h0, dbits}, {9'h0, cur_st});
                        else
                            check(dbits == cur_st || dbits == prev_st, "R3 frame payload after change",
                                  {9'h0, dbits}, {9'h0, cur_st});
                        if (hb_ok)
                            check(hb == dbits, "R4 high byte equals frame on line", {9'h0, hb}, {9'h0, dbits});
                        fsince++;
                        frames++;
                        dphase = 0; gap = 0;
                    end
                end
            end
            tx_prev = tx_line;
        end
    end

    task automatic drive_bit(input logic v);
        @(posedge clk); #1 rx_line = v;
        repeat (BITC - 1) @(posedge clk);
    endtask

    task automatic send_frame(input logic [6:0] d, input bit stop_ok);
        rx_busy = 1;
        drive_bit(1'b0);
        for (int i = 0; i < 7; i++) drive_bit(d[i]);
        drive_bit(stop_ok);
        @(posedge clk); #1 rx_line = 1'b1;
        repeat (12) @(posedge clk);
        if (stop_ok) exp_rx = d;
        #1 rx_busy = 0;
        repeat (2 * BITC) @(posedge clk);
    endtask

    task automatic set_status(input logic [6:0] s);
        @(posedge clk); #1;
        prev_st = cur_st; cur_st = s; status_in = s; fsince = 0;
        repeat (1200) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check(tx_line == 1'b1, "R1 tx_line high in reset", {15'h0, tx_line}, 16'h1);
        check(rd_data == 16'h0, "R1 rd_data zero in reset", rd_data, 16'h0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(tx_line == 1'b1, "R1 tx_line high after reset", {15'h0, tx_line}, 16'h1);
        check(rd_data == 16'h0, "R1 rd_data zero after reset", rd_data, 16'h0);

        repeat (3 * BITC) @(posedge clk);
        // R5 basic receive
        send_frame(7'h5A, 1);
        @(negedge clk);
        check(rd_data[7:0] == 8'h5A, "R5 decode 5A", {8'h0, rd_data[7:0]}, 16'h005A);

        set_status(7'h01);

        send_frame(7'h7F, 1);
        @(negedge clk);
        check(rd_data[7:0] == 8'h7F, "R5 decode 7F", {8'h0, rd_data[7:0]}, 16'h007F);
        send_frame(7'h00, 1);
        @(negedge clk);
        check(rd_data[7:0] == 8'h00, "R5 decode 00", {8'h0, rd_data[7:0]}, 16'h0000);
        send_frame(7'h4C, 1);

        // R6 bad stop bit dropped, later frame accepted
        send_frame(7'h33, 0);
        @(negedge clk);
        check(rd_data[7:0] == 8'h4C, "R6 bad stop keeps old", {8'h0, rd_data[7:0]}, 16'h004C);
        send_frame(7'h21, 1);
        @(negedge clk);
        check(rd_data[7:0] == 8'h21, "R6 recovery after bad stop", {8'h0, rd_data[7:0]}, 16'h0021);

        // R7 short low glitch
        @(posedge clk); #1 rx_line = 1'b0;
        repeat (3) @(posedge clk);
        #1 rx_line = 1'b1;
        repeat (3 * BITC) @(posedge clk);
        @(negedge clk);
        check(rd_data[7:0] == 8'h21, "R7 glitch ignored", {8'h0, rd_data[7:0]}, 16'h0021);
        send_frame(7'h15, 1);
        @(negedge clk);
        check(rd_data[7:0] == 8'h15, "R7 frame after glitch", {8'h0, rd_data[7:0]}, 16'h0015);

        // R8 read register holds without strobe
        @(posedge clk); #1 cmp_en = 0; rd_en = 1'b0;
        send_frame(7'h12, 1);
        @(negedge clk);
        check(rd_data[7:0] == 8'h15, "R8 hold without rd_en", {8'h0, rd_data[7:0]}, 16'h0015);
        @(posedge clk); #1 rd_en = 1'b1;
        repeat (2) @(negedge clk);
        check(rd_data[7:0] == 8'h12, "R8 update on rd_en", {8'h0, rd_data[7:0]}, 16'h0012);
        cmp_en = 1;

        set_status(7'h40);
        set_status(7'h7F);

        check(frames >= 20, "R3 continuous frame count", 16'(frames), 16'd20);
        finish_run();
    end
endmodule